// File: doc/BRIEF.md
# Frame Timestamp Scanline Estimator

This block reports the display line currently being scanned out when no usable hardware line counter exists. A free-running timestamp counter advances once per clock (one tick is taken as one microsecond). Every start-of-vblank pulse copies the counter into a frame-timestamp register. On a request, the block reads the frame timestamp and then the current time. It converts the difference into a number of whole lines using the pixel clock in kHz and the horizontal total. The result is clamped and then rebased so that line counting starts at the first vblank line.

Reading the two values takes more than one cycle, so a vblank capture can land between them. To catch this, the block compares the frame timestamp it read first with the value present just after the current time was taken. If they differ, it reads again. The line count comes from a restoring divider that produces one quotient bit per cycle. A one-cycle valid pulse marks each result. While a computation is in flight, new requests are dropped.

Top module: `scanline_estimator`

## Requirements
- R1: After reset the timestamp counter is 0. It then adds one on every clock and wraps modulo 2^TS_W. Elapsed time is the current sample minus the frame timestamp, taken modulo 2^TS_W, so a wrap between the two samples gives the true distance.
- R2: At the clock edge that samples `vblankStart` high, the frame timestamp takes the counter value from just before that edge, and the block records that a capture has occurred.
- R3: The elapsed line count is floor(elapsed × `pixClkKhz` / (1000 × `hTotal`)).
- R4: An elapsed line count above `vTotal` − 1 is replaced by `vTotal` − 1.
- R5: The reported `scanline` is (clamped line count + `vblankLine`) modulo `vTotal`, for `vblankLine` < `vTotal`.
- R6: If the frame timestamp (or the capture flag) changes between the frame-timestamp read and the check that follows the current-time read, both reads are repeated. Each retry adds 2 cycles, and the result uses only the new frame timestamp.
- R7: `respValid` is high for exactly one cycle. It rises TS_W+CLK_W+3 clock edges after the edge that accepts `reqValid`, which leaves 2 edges for the reads, TS_W+CLK_W divider steps and 1 edge to register the result.
- R8: A `reqValid` that arrives while a computation is in progress is ignored and produces no further `respValid` pulse.
- R9: A request handled before any vblank capture since reset reports `scanline` = 0.
- R10: While reset is held, and right after it, `respValid` is 0 and `scanline` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each cycle is one timestamp tick |
| rstN | input | 1 | Asynchronous active-low reset |
| vblankStart | input | 1 | Single-cycle start-of-vblank pulse |
| reqValid | input | 1 | Request for a scanline estimate |
| pixClkKhz | input | CLK_W | Pixel clock in kHz |
| hTotal | input | LINE_W | Pixels per line including blanking |
| vTotal | input | LINE_W | Lines per frame (at least 1) |
| vblankLine | input | LINE_W | Line number at which vblank begins |
| respValid | output | 1 | One-cycle pulse: `scanline` is new |
| scanline | output | LINE_W | Estimated current line |

## Verification
The conversion is tried against several display modes and elapsed gaps. Some give an unclamped line count that stays below `vTotal` after rebasing, and others wrap past `vTotal`. Together these separate a wrong quotient from a missing modulo step. One case has so much elapsed time that only the clamp gives the right answer. Another places the capture just below the counter wrap, which exposes a subtraction that is not modular. A capture forced into the read window must add exactly one retry and yield the rebased vblank line. A request before any capture must return 0, and a request during the division must not produce a second pulse.

// File: rtl/est_pkg.sv
package est_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic samplePre;   // latch frame timestamp and capture flag
    logic sampleCur;   // latch running time
    logic loadDiv;     // start the line division
    logic finish;      // register clamped, rebased result
  } estStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CURR,
    ST_CHECK,
    ST_DIV
  } estState_t;

  localparam int unsigned KHZ_SCALE   = 1000;
  localparam int unsigned KHZ_SCALE_W = 10;

endpackage

// File: rtl/est_timebase.sv
module est_timebase #(
  parameter int unsigned TS_W = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            vblankStart,
  output logic [TS_W-1:0] tsNow,
  output logic [TS_W-1:0] frameTs,
  output logic            captured
);

  // Free-running time base, wraps naturally (R1)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tsNow <= '0;
    else       tsNow <= tsNow + TS_W'(1);
  end

  // Frame timestamp captured at start of vblank (R2)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameTs  <= '0;
      captured <= 1'b0;
    end else if (vblankStart) begin
      frameTs  <= tsNow;
      captured <= 1'b1;
    end
  end

endmodule

// File: rtl/est_divider.sv
module est_divider #(
  parameter int unsigned NUM_W = 52,
  parameter int unsigned DEN_W = 26
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [NUM_W-1:0] numer,
  input  logic [DEN_W-1:0] denom,
  output logic [NUM_W-1:0] quot,
  output logic             done
);

  localparam int unsigned CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] remQ;
  logic [DEN_W-1:0] denQ;
  logic [CNT_W-1:0] stepCnt;
  logic             busy;

  logic [DEN_W:0]   trial;
  logic             fits;
  logic [DEN_W:0]   trialLess;
  logic [DEN_W-1:0] remNext;

  // Restoring step: shift one numerator bit into the remainder
  always_comb begin
    trial     = {remQ, quot[NUM_W-1]};
    fits      = trial >= {1'b0, denQ};
    trialLess = trial - {1'b0, denQ};
    remNext   = fits ? DEN_W'(trialLess) : DEN_W'(trial);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remQ    <= '0;
      denQ    <= '0;
      quot    <= '0;
      stepCnt <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        remQ    <= '0;
        denQ    <= denom;
        quot    <= numer;
        stepCnt <= '0;
        busy    <= 1'b1;
      end else if (busy) begin
        remQ    <= remNext;
        quot    <= {quot[NUM_W-2:0], fits};
        stepCnt <= stepCnt + CNT_W'(1);
        if (stepCnt == CNT_W'(NUM_W - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/est_datapath.sv
module est_datapath
  import est_pkg::*;
#(
  parameter int unsigned TS_W   = 32,
  parameter int unsigned CLK_W  = 20,
  parameter int unsigned LINE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  estStrobe_t        stb,
  input  logic [TS_W-1:0]   tsNow,
  input  logic [TS_W-1:0]   frameTs,
  input  logic              captured,
  input  logic [CLK_W-1:0]  pixClkKhz,
  input  logic [LINE_W-1:0] hTotal,
  input  logic [LINE_W-1:0] vTotal,
  input  logic [LINE_W-1:0] vblankLine,
  output logic              mismatch,
  output logic              divDone,
  output logic              respValid,
  output logic [LINE_W-1:0] scanline
);

  localparam int unsigned NUM_W = TS_W + CLK_W;
  localparam int unsigned DEN_W = LINE_W + KHZ_SCALE_W;

  logic [TS_W-1:0]   preTs;
  logic              preCap;
  logic [TS_W-1:0]   curTs;
  logic [TS_W-1:0]   elapsed;
  logic [NUM_W-1:0]  numer;
  logic [DEN_W-1:0]  denom;
  logic [NUM_W-1:0]  quot;
  logic [LINE_W-1:0] lineMax;
  logic [LINE_W-1:0] lines;
  logic [LINE_W:0]   rebased;
  logic [LINE_W:0]   rebasedLess;
  logic [LINE_W:0]   wrapped;

  // Read-window bookkeeping for the consistency check (R6)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preTs  <= '0;
      preCap <= 1'b0;
      curTs  <= '0;
    end else begin
      if (stb.samplePre) begin
        preTs  <= frameTs;
        preCap <= captured;
      end
      if (stb.sampleCur) curTs <= tsNow;
    end
  end

  assign mismatch = (frameTs != preTs) || (captured != preCap);

  // Modular elapsed time and the division operands (R1, R3)
  always_comb begin
    elapsed = curTs - preTs;
    numer   = NUM_W'(elapsed) * NUM_W'(pixClkKhz);
    denom   = DEN_W'(hTotal) * DEN_W'(KHZ_SCALE);
  end

  est_divider #(
    .NUM_W(NUM_W),
    .DEN_W(DEN_W)
  ) u_div (
    .clk   (clk),
    .rstN  (rstN),
    .start (stb.loadDiv),
    .numer (numer),
    .denom (denom),
    .quot  (quot),
    .done  (divDone)
  );

  // Clamp (R4) and rebase onto the vblank line (R5)
  always_comb begin
    lineMax     = vTotal - LINE_W'(1);
    lines       = (quot > NUM_W'(lineMax)) ? lineMax : LINE_W'(quot);
    rebased     = {1'b0, lines} + {1'b0, vblankLine};
    rebasedLess = rebased - {1'b0, vTotal};
    wrapped     = (rebased >= {1'b0, vTotal}) ? rebasedLess : rebased;
  end

  // Result register and one-cycle valid (R7, R9, R10)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      scanline  <= '0;
    end else begin
      respValid <= stb.finish;
      if (stb.finish) scanline <= preCap ? LINE_W'(wrapped) : '0;
    end
  end

endmodule

// File: rtl/est_ctrl.sv
module est_ctrl
  import est_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       mismatch,
  input  logic       divDone,
  output estStrobe_t stb
);

  estState_t state;
  estState_t stateNext;

  always_comb begin
    stb       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          stb.samplePre = 1'b1;
          stateNext     = ST_CURR;
        end
      end
      ST_CURR: begin
        stb.sampleCur = 1'b1;
        stateNext     = ST_CHECK;
      end
      ST_CHECK: begin
        if (mismatch) begin
          // capture landed inside the read window: read again (R6)
          stb.samplePre = 1'b1;
          stateNext     = ST_CURR;
        end else begin
          stb.loadDiv = 1'b1;
          stateNext   = ST_DIV;
        end
      end
      ST_DIV: begin
        // reqValid is not looked at here (R8)
        if (divDone) begin
          stb.finish = 1'b1;
          stateNext  = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/scanline_estimator.sv
module scanline_estimator
  import est_pkg::*;
#(
  parameter int unsigned TS_W   = 32,
  parameter int unsigned CLK_W  = 20,
  parameter int unsigned LINE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vblankStart,
  input  logic              reqValid,
  input  logic [CLK_W-1:0]  pixClkKhz,
  input  logic [LINE_W-1:0] hTotal,
  input  logic [LINE_W-1:0] vTotal,
  input  logic [LINE_W-1:0] vblankLine,
  output logic              respValid,
  output logic [LINE_W-1:0] scanline
);

  estStrobe_t      stb;
  logic [TS_W-1:0] tsNow;
  logic [TS_W-1:0] frameTs;
  logic            captured;
  logic            mismatch;
  logic            divDone;

  est_timebase #(.TS_W(TS_W)) u_tb (
    .clk         (clk),
    .rstN        (rstN),
    .vblankStart (vblankStart),
    .tsNow       (tsNow),
    .frameTs     (frameTs),
    .captured    (captured)
  );

  est_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .mismatch (mismatch),
    .divDone  (divDone),
    .stb      (stb)
  );

  est_datapath #(
    .TS_W   (TS_W),
    .CLK_W  (CLK_W),
    .LINE_W (LINE_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .tsNow      (tsNow),
    .frameTs    (frameTs),
    .captured   (captured),
    .pixClkKhz  (pixClkKhz),
    .hTotal     (hTotal),
    .vTotal     (vTotal),
    .vblankLine (vblankLine),
    .mismatch   (mismatch),
    .divDone    (divDone),
    .respValid  (respValid),
    .scanline   (scanline)
  );

endmodule

// File: rtl/est_checker.sv
module est_checker #(
  parameter int unsigned TS_W   = 32,
  parameter int unsigned LINE_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              vblankStart,
  input logic              respValid,
  input logic [LINE_W-1:0] scanline,
  input logic [LINE_W-1:0] vTotal,
  input logic [LINE_W-1:0] vblankLine,
  input logic [TS_W-1:0]   tsNow,
  input logic [TS_W-1:0]   frameTs,
  input logic              captured
);

  a_r1_ts_advance: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> tsNow == $past(tsNow) + TS_W'(1));

  a_r2_frame_capture: assert property (@(posedge clk) disable iff (!rstN)
    vblankStart |=> (frameTs == $past(tsNow)) && captured);

  a_r5_scanline_range: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && vTotal != '0 && vblankLine < vTotal) |-> scanline < vTotal);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid);

  a_r9_zero_uncaptured: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !captured) |-> scanline == '0);

endmodule

bind scanline_estimator est_checker #(
  .TS_W   (TS_W),
  .LINE_W (LINE_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .vblankStart (vblankStart),
  .respValid   (respValid),
  .scanline    (scanline),
  .vTotal      (vTotal),
  .vblankLine  (vblankLine),
  .tsNow       (tsNow),
  .frameTs     (frameTs),
  .captured    (captured)
);

// File: tb/scanline_estimator_test.sv
`timescale 1ns/1ps
module scanline_estimator_test;

  localparam int TS_W   = 12;
  localparam int CLK_W  = 20;
  localparam int LINE_W = 16;
  localparam int LAT    = TS_W + CLK_W + 3;
  localparam int TS_MASK = (1 << TS_W) - 1;

  typedef struct packed {
    logic [31:0] pix;
    logic [31:0] ht;
    logic [31:0] vt;
    logic [31:0] vbs;
    logic [31:0] gap;
  } vec_t;

  // pix kHz, htotal, vtotal, vblank line, cycles from capture to request
  localparam vec_t VECS [0:4] = '{
    '{32'd148500, 32'd2200, 32'd1125, 32'd1084, 32'd300},
    '{32'd25175,  32'd800,  32'd525,  32'd480,  32'd1000},
    '{32'd148500, 32'd200,  32'd40,   32'd30,   32'd2000},
    '{32'd74250,  32'd1650, 32'd750,  32'd720,  32'd50},
    '{32'd100000, 32'd1000, 32'd100,  32'd90,   32'd500}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              vblankStart = 1'b0;
  logic              reqValid = 1'b0;
  logic [CLK_W-1:0]  pixClkKhz = '0;
  logic [LINE_W-1:0] hTotal = '0;
  logic [LINE_W-1:0] vTotal = '0;
  logic [LINE_W-1:0] vblankLine = '0;
  logic              respValid;
  logic [LINE_W-1:0] scanline;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  int tbTs = 0;

  always #4 clk = ~clk;

  // Bench time reference, following R1
  always @(posedge clk) begin
    if (!rstN) tbTs <= 0;
    else       tbTs <= (tbTs + 1) & TS_MASK;
  end

  scanline_estimator #(
    .TS_W(TS_W), .CLK_W(CLK_W), .LINE_W(LINE_W)
  ) uut (
    .clk(clk), .rstN(rstN), .vblankStart(vblankStart), .reqValid(reqValid),
    .pixClkKhz(pixClkKhz), .hTotal(hTotal), .vTotal(vTotal),
    .vblankLine(vblankLine), .respValid(respValid), .scanline(scanline)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint expLine(input int frameV, input int curV, input bit cap,
                                     input longint pix, input longint ht,
                                     input longint vt, input longint vbs);
    longint diff;
    longint lines;
    diff  = longint'((curV - frameV) & TS_MASK);
    lines = (diff * pix) / (1000 * ht);
    if (lines > vt - 1) lines = vt - 1;
    return cap ? (lines + vbs) % vt : 0;
  endfunction

  task automatic setMode(input vec_t v);
    pixClkKhz  = CLK_W'(v.pix);
    hTotal     = LINE_W'(v.ht);
    vTotal     = LINE_W'(v.vt);
    vblankLine = LINE_W'(v.vbs);
  endtask

  // Called at a negedge; returns at the negedge after the capture edge
  task automatic doVblank(output int frameV);
    vblankStart = 1'b1;
    frameV = tbTs;
    @(negedge clk);
    vblankStart = 1'b0;
  endtask

  // Called at a negedge; waits for the response
  task automatic doRequest(output int curV, output int lat, output int got);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    curV = tbTs;
    lat = 0;
    while (!respValid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    got = int'(scanline);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int frameV, curV, lat, got, frame2, pulses;

    // R10: reset state
    repeat (3) @(negedge clk);
    check("R10 respValid in reset", respValid, 0);
    check("R10 scanline in reset", scanline, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 respValid after reset", respValid, 0);

    // R9: request before any capture
    setMode(VECS[0]);
    repeat (20) @(negedge clk);
    doRequest(curV, lat, got);
    check("R9 no capture yet gives 0", got, 0);

    // R3 R4 R5 R7: table of modes and gaps
    for (int i = 0; i < 5; i++) begin
      setMode(VECS[i]);
      doVblank(frameV);
      repeat (int'(VECS[i].gap) - 1) @(negedge clk);
      doRequest(curV, lat, got);
      check($sformatf("R3 R4 R5 vector %0d scanline", i), got,
            expLine(frameV, curV, 1'b1, VECS[i].pix, VECS[i].ht, VECS[i].vt, VECS[i].vbs));
      check($sformatf("R7 vector %0d latency", i), lat, LAT);
    end

    // R4 explicit: clamp case lands on vblank line - 1
    setMode(VECS[2]);
    doVblank(frameV);
    repeat (1999) @(negedge clk);
    doRequest(curV, lat, got);
    check("R4 clamp to vtotal-1 then rebase", got, 29);

    // R1: counter wraps between capture and request
    setMode(VECS[1]);
    while (tbTs != 3900) @(negedge clk);
    doVblank(frameV);
    repeat (599) @(negedge clk);
    doRequest(curV, lat, got);
    check("R1 wrapped timestamp current below frame", curV < frameV, 1);
    check("R1 wrapped elapsed scanline", got,
          expLine(frameV, curV, 1'b1, VECS[1].pix, VECS[1].ht, VECS[1].vt, VECS[1].vbs));

    // R6: capture lands inside the read window
    setMode(VECS[0]);
    doVblank(frameV);
    repeat (1500) @(negedge clk);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    vblankStart = 1'b1;
    frame2 = tbTs;
    @(negedge clk);
    vblankStart = 1'b0;
    lat = 1;
    while (!respValid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    got = int'(scanline);
    check("R6 retry uses new frame timestamp", got,
          expLine(frame2, frame2 + 2, 1'b1, VECS[0].pix, VECS[0].ht, VECS[0].vt, VECS[0].vbs));
    check("R6 retry adds two cycles", lat, LAT + 2);
    @(negedge clk);

    // R8: request while busy is dropped
    setMode(VECS[3]);
    doVblank(frameV);
    repeat (99) @(negedge clk);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    curV = tbTs;
    repeat (10) @(negedge clk);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    pulses = 0;
    got = -1;
    for (int k = 0; k < 3 * LAT; k++) begin
      if (respValid) begin
        pulses++;
        if (got < 0) got = int'(scanline);
      end
      @(negedge clk);
    end
    check("R8 single response for busy request", pulses, 1);
    check("R8 result of the accepted request", got,
          expLine(frameV, curV, 1'b1, VECS[3].pix, VECS[3].ht, VECS[3].vt, VECS[3].vbs));

    // R7: a request right after completion is served
    doRequest(curV, lat, got);
    check("R7 back-to-back request latency", lat, LAT);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule